// File: doc/BRIEF.md
# Serial EEPROM Bus Target Controller

This block is the protocol side of a two-wire serial memory target that fronts a 2 KiB byte-addressed nonvolatile array. Both bus lines are oversampled in the system clock domain. The block finds bus start and stop events and moves bytes most-significant bit first in both directions. It owns an 11-bit address pointer and returns acknowledges through an open-drain pull-down enable. Bytes received in a write are pushed, each with its full address, to an external page buffer. A one-cycle commit pulse at the bus stop tells the write engine to start programming. Reads are served from a synchronous read port with one cycle of latency.

The write engine raises a busy input while it programs. For that whole time the block answers nothing, so a bus master can poll with control bytes until it gets an acknowledge. A write-protect input turns the array into a read-only store. Only one such target can sit on a bus, because the three select bits of the control byte are used as the top of the word address.

Top module: `eeprom_bus_target`

## Requirements
- R1: After reset the SDA pull-down enable is low and no push, commit or read strobe is active.
- R2: A start event (SDA falling while SCL is high) in any state drops the transfer in progress and starts receiving a control byte. The pointer is left untouched.
- R3: A control byte is acknowledged only when its bits 7:4 equal 1010. Bits 3:1 select the 256-byte block, and bit 0 = 1 means read. Any other code is not acknowledged, and all later bytes are ignored until the next start or stop.
- R4: While busy_i is high, no control byte is acknowledged, even one with a matching code.
- R5: In a write, the word-address byte and every data byte are acknowledged. Each data byte is pushed with address {block, word}. A stop after at least one pushed byte gives exactly one commit pulse, one cycle long.
- R6: In a multi-byte write, the pointer's low 4 bits advance after each byte and wrap within the 16-byte page, while bits 10:4 stay fixed. Bytes beyond 16 overwrite earlier page locations in arrival order.
- R7: A write that has only a control byte and a word address, ended by a repeated start, sets the pointer and gives no commit. A following read returns the byte at that address.
- R8: A read returns the byte at the pointer, then advances the pointer by one over the whole 11-bit range, wrapping from 7FF to 000.
- R9: In a read, an acknowledge from the master makes the block send the next byte. A missing acknowledge makes it release SDA and issue no more read strobes until a start or stop.
- R10: While wp_i is high, write bytes are still acknowledged but nothing is pushed and no commit follows. Reads are unaffected.
- R11: The SDA enable changes only while the synchronized SCL is low.
- R12: Bytes are received and sent most-significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wp_i | input | 1 | Write protect, 1 blocks all writes |
| busy_i | input | 1 | Internal programming cycle in progress |
| push_valid_o | output | 1 | One-cycle strobe for a received write byte |
| push_addr_o | output | 11 | Array address of the pushed byte |
| push_data_o | output | 8 | Pushed byte |
| commit_o | output | 1 | One-cycle pulse that starts programming |
| rd_en_o | output | 1 | Read strobe to the array |
| rd_addr_o | output | 11 | Read address |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_en_o |

## Verification
The bench writes a 17th and an 18th byte into one page. A design that carried the page increment into bit 4 would land those bytes in the next page and leave the first two page locations holding their first values. A sequential read starting at 7FE has to come back as 7FE, 7FF, 000, 001. A pointer that saturates, or that keeps the page wrap on reads, would return wrong data there. Other stimuli are an address-only write ended by a repeated start, which must not commit; a start in the middle of an address byte, which must leave the pointer alone; and control bytes sent while busy_i is high or with a wrong device code, which must stay unacknowledged. A design that ignores busy_i, or leaks a commit from a write that was cut off, fails those checks.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RACK,
        S_TX,
        S_TACK,
        S_WAIT
    } ebt_state_e;

    typedef enum logic [1:0] {
        K_CTRL,
        K_WADDR,
        K_WDATA
    } ebt_kind_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;
endpackage

// File: rtl/ebt_bus_sync.sv
module ebt_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
    logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
    logic              scl_prev_q, sda_prev_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_lvl_o  = scl_pipe_q[STAGES-1];
    assign sda_lvl_o  = sda_pipe_q[STAGES-1];
    assign scl_rise_o = scl_lvl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_lvl_o & scl_prev_q;
    // data edges only count as events while the clock line stays high
    assign start_o    = scl_lvl_o & scl_prev_q & sda_prev_q & ~sda_lvl_o;
    assign stop_o     = scl_lvl_o & scl_prev_q & ~sda_prev_q & sda_lvl_o;
endmodule

// File: rtl/ebt_addr_ptr.sv
module ebt_addr_ptr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              page_inc_i,
    input  logic              lin_inc_i,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [PAGE_W-1:0] low_next;

    always_comb begin
        low_next = ptr_q[PAGE_W-1:0] + 1'b1;
        ptr_d    = ptr_q;
        if (load_i) begin
            ptr_d = load_val_i;
        end else if (page_inc_i) begin
            ptr_d = {ptr_q[ADDR_W-1:PAGE_W], low_next};
        end else if (lin_inc_i) begin
            ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/eeprom_bus_target.sv
module eeprom_bus_target
    import ebt_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wp_i,
    input  logic              busy_i,
    output logic              push_valid_o,
    output logic [ADDR_W-1:0] push_addr_o,
    output logic [7:0]        push_data_o,
    output logic              commit_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);
    localparam int BLK_W = ADDR_W - BYTE_W;

    typedef struct packed {
        ebt_state_e        st;
        ebt_kind_e         kind;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              oe;
        logic              rnw;
        logic [BLK_W-1:0]  blk;
        logic              seen;
        logic              mack;
        logic              push;
        logic [ADDR_W-1:0] paddr;
        logic [7:0]        pdata;
        logic              commit;
        logic              rd;
        logic [ADDR_W-1:0] raddr;
        logic              cap;
    } ebt_regs_t;

    ebt_regs_t r_q, r_d;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              ptr_load, ptr_pinc, ptr_linc;
    logic [ADDR_W-1:0] ptr_ld_val, ptr;

    ebt_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    ebt_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(ptr_load), .load_val_i(ptr_ld_val),
        .page_inc_i(ptr_pinc), .lin_inc_i(ptr_linc), .ptr_o(ptr)
    );

    always_comb begin
        r_d        = r_q;
        ptr_load   = 1'b0;
        ptr_ld_val = '0;
        ptr_pinc   = 1'b0;
        ptr_linc   = 1'b0;
        r_d.push   = 1'b0;
        r_d.commit = 1'b0;
        r_d.rd     = 1'b0;
        r_d.cap    = r_q.rd;
        if (r_q.cap) r_d.sh = rd_data_i;

        if (start_det) begin
            r_d.st   = S_RX;
            r_d.kind = K_CTRL;
            r_d.cnt  = '0;
            r_d.oe   = 1'b0;
            r_d.seen = 1'b0;
        end else if (stop_det) begin
            r_d.st     = S_IDLE;
            r_d.oe     = 1'b0;
            r_d.commit = r_q.seen;
            r_d.seen   = 1'b0;
        end else begin
            case (r_q.st)
                S_RX: begin
                    if (scl_rise && r_q.cnt < 4'd8) begin
                        r_d.sh  = {r_q.sh[6:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.st = S_RACK;
                        r_d.oe = 1'b1;
                        case (r_q.kind)
                            K_CTRL: begin
                                if (r_q.sh[7:4] == DEV_CODE && !busy_i) begin
                                    r_d.rnw = r_q.sh[0];
                                    r_d.blk = r_q.sh[3:1];
                                    if (r_q.sh[0]) begin
                                        r_d.rd    = 1'b1;
                                        r_d.raddr = ptr;
                                        ptr_linc  = 1'b1;
                                    end
                                end else begin
                                    r_d.st = S_WAIT;
                                    r_d.oe = 1'b0;
                                end
                            end
                            K_WADDR: begin
                                ptr_load   = 1'b1;
                                ptr_ld_val = {r_q.blk, r_q.sh};
                            end
                            default: begin
                                if (!wp_i) begin
                                    r_d.push  = 1'b1;
                                    r_d.paddr = ptr;
                                    r_d.pdata = r_q.sh;
                                    r_d.seen  = 1'b1;
                                end
                                ptr_pinc = 1'b1;
                            end
                        endcase
                    end
                end
                S_RACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.kind == K_CTRL && r_q.rnw) begin
                            r_d.st = S_TX;
                            r_d.oe = ~r_q.sh[7];
                        end else begin
                            r_d.st   = S_RX;
                            r_d.oe   = 1'b0;
                            r_d.kind = (r_q.kind == K_CTRL) ? K_WADDR : K_WDATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == 4'd8) begin
                            r_d.oe  = 1'b0;
                            r_d.st  = S_TACK;
                            r_d.cnt = '0;
                        end else begin
                            r_d.sh = {r_q.sh[6:0], 1'b0};
                            r_d.oe = ~r_q.sh[6];
                        end
                    end
                end
                S_TACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_lvl;
                        if (!sda_lvl) begin
                            r_d.rd    = 1'b1;
                            r_d.raddr = ptr;
                            ptr_linc  = 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st = S_TX;
                            r_d.oe = ~r_q.sh[7];
                        end else begin
                            r_d.st = S_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.kind <= K_CTRL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o     = r_q.oe;
    assign push_valid_o = r_q.push;
    assign push_addr_o  = r_q.paddr;
    assign push_data_o  = r_q.pdata;
    assign commit_o     = r_q.commit;
    assign rd_en_o      = r_q.rd;
    assign rd_addr_o    = r_q.raddr;
endmodule

// File: rtl/ebt_checker.sv
module ebt_checker
    import ebt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       stop_det,
    input ebt_state_e st,
    input ebt_kind_e  kind,
    input logic       sda_oe_o,
    input logic       busy_i,
    input logic       wp_i,
    input logic       push_valid_o,
    input logic       commit_o,
    input logic       rd_en_o
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_lvl)); // R11

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && st == S_RACK && kind == K_CTRL) |-> $past(!busy_i)); // R4

    AST_WP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid_o |-> $past(!wp_i)); // R10

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_det)); // R5

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R5

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o); // R9
endmodule

bind eeprom_bus_target ebt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .stop_det(stop_det),
    .st(r_q.st), .kind(r_q.kind), .sda_oe_o(sda_oe_o), .busy_i(busy_i),
    .wp_i(wp_i), .push_valid_o(push_valid_o), .commit_o(commit_o),
    .rd_en_o(rd_en_o)
);

// File: tb/eeprom_bus_target_tb.sv
module eeprom_bus_target_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wp = 1'b0, busy = 1'b0;
    logic line;
    logic sda_oe, push_v, commit, rd_en;
    logic [10:0] push_a, rd_a;
    logic [7:0]  push_d, rd_data;
    logic [7:0]  mem [2048];
    int n_chk = 0, n_fail = 0, n_push = 0, n_rd = 0, n_commit = 0, n_bad_oe = 0;
    logic [10:0] last_pa;
    logic [7:0]  last_pd;
    logic oe_prev = 1'b0;

    always #2 clk = ~clk;
    assign line = sda_m & ~sda_oe;

    eeprom_bus_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe_o(sda_oe),
        .wp_i(wp), .busy_i(busy), .push_valid_o(push_v), .push_addr_o(push_a),
        .push_data_o(push_d), .commit_o(commit), .rd_en_o(rd_en),
        .rd_addr_o(rd_a), .rd_data_i(rd_data)
    );

    function automatic logic [7:0] fill(input int a);
        return 8'((a * 37) ^ (a >> 3));
    endfunction

    always @(posedge clk) begin
        if (push_v) begin
            mem[push_a] <= push_d;
            last_pa <= push_a;
            last_pd <= push_d;
            n_push <= n_push + 1;
        end
        if (rd_en) begin
            rd_data <= mem[rd_a];
            n_rd <= n_rd + 1;
        end
        if (commit) n_commit <= n_commit + 1;
        if (rst_n && (sda_oe !== oe_prev) && scl_m) n_bad_oe <= n_bad_oe + 1;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bstop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
    endtask

    task automatic bbit(input logic b, output logic s);
        sda_m = b; qw(); scl_m = 1'b1; qw(); s = line; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bbit(b[i], s);
        bbit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bbit(1'b1, s);
            d[i] = s;
        end
        bbit(~mack, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int base_push, base_commit, base_rd;
        for (int a = 0; a < 2048; a++) mem[a] = fill(a);
        rd_data = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 oe", sda_oe, 0);
        chk("R1 strobes", int'(push_v) + int'(commit) + int'(rd_en), 0);

        // R5 byte write into block 3, R12 asymmetric address and data
        bstart();
        wbyte(8'hA6, ack); chk("R3 ctrl ack", ack, 1);
        wbyte(8'h34, ack); chk("R5 addr ack", ack, 1);
        wbyte(8'h5A, ack); chk("R5 data ack", ack, 1);
        bstop();
        chk("R5 push addr", last_pa, 11'h334);
        chk("R12 push data", last_pd, 8'h5A);
        chk("R5 commit", n_commit, 1);

        // R3 wrong device code, following byte ignored
        bstart();
        wbyte(8'hB0, ack); chk("R3 bad code nack", ack, 0);
        wbyte(8'hA0, ack); chk("R3 ignored after nack", ack, 0);
        bstop();

        // R4 busy: no ack even for matching code
        busy = 1'b1;
        bstart();
        wbyte(8'hA0, ack); chk("R4 busy nack", ack, 0);
        bstop();
        busy = 1'b0;
        bstart();
        wbyte(8'hA0, ack); chk("R4 ack after busy", ack, 1);
        bstop();

        // R7 random read: address-only write then repeated start
        base_commit = n_commit;
        bstart();
        wbyte(8'hA6, ack);
        wbyte(8'h34, ack);
        bstart();
        wbyte(8'hA7, ack); chk("R7 read ctrl ack", ack, 1);
        rbyte(1'b0, d);
        chk("R12 random read data", d, 8'h5A);
        bstop();
        chk("R7 no commit", n_commit, base_commit);

        // R8 current-address read returns next location
        bstart();
        wbyte(8'hA1, ack);
        rbyte(1'b0, d);
        bstop();
        chk("R8 current read", d, fill(11'h335));

        // R8/R9 sequential read across the top of the array
        base_rd = n_rd;
        bstart();
        wbyte(8'hAE, ack);
        wbyte(8'hFE, ack);
        bstart();
        wbyte(8'hAF, ack);
        rbyte(1'b1, d); chk("R8 seq 7FE", d, fill(11'h7FE));
        rbyte(1'b1, d); chk("R8 seq 7FF", d, fill(11'h7FF));
        rbyte(1'b1, d); chk("R8 seq wrap 000", d, fill(0));
        rbyte(1'b0, d); chk("R9 seq 001", d, fill(1));
        chk("R9 line released after nack", line, 1);
        bstop();
        chk("R9 read strobe count", n_rd - base_rd, 4);

        // R6 page write, 18 bytes from offset E in page 0x110
        base_push = n_push;
        base_commit = n_commit;
        bstart();
        wbyte(8'hA2, ack);
        wbyte(8'h1E, ack);
        for (int i = 0; i < 18; i++) wbyte(8'(8'h80 + i), ack);
        bstop();
        chk("R6 push count", n_push - base_push, 18);
        chk("R5 page commit", n_commit - base_commit, 1);
        for (int o = 0; o < 16; o++) begin
            int last_i;
            last_i = 0;
            for (int i = 0; i < 18; i++) if (((14 + i) % 16) == o) last_i = i;
            chk("R6 page content", mem[11'h110 + o], 8'h80 + last_i);
        end
        chk("R6 neighbour page untouched", mem[11'h10F], fill(11'h10F));
        chk("R6 next page untouched", mem[11'h120], fill(11'h120));

        // R10 write protect
        wp = 1'b1;
        base_push = n_push;
        base_commit = n_commit;
        bstart();
        wbyte(8'hA0, ack);
        wbyte(8'h05, ack);
        wbyte(8'h11, ack); chk("R10 data acked", ack, 1);
        bstop();
        chk("R10 no push", n_push - base_push, 0);
        chk("R10 no commit", n_commit - base_commit, 0);
        bstart();
        wbyte(8'hA0, ack);
        wbyte(8'h05, ack);
        bstart();
        wbyte(8'hA1, ack);
        rbyte(1'b0, d);
        bstop();
        chk("R10 read unaffected", d, fill(5));
        wp = 1'b0;

        // R2 start in the middle of an address byte keeps the pointer at 006
        bstart();
        wbyte(8'hA0, ack);
        begin
            logic s;
            bbit(1'b0, s); bbit(1'b1, s); bbit(1'b0, s); bbit(1'b0, s);
        end
        bstart();
        wbyte(8'hA1, ack); chk("R2 ack after abort", ack, 1);
        rbyte(1'b0, d);
        bstop();
        chk("R2 pointer kept", d, fill(6));

        chk("R11 oe changes only with SCL low", n_bad_oe, 0);
        report();
    end
endmodule